// File: doc/BRIEF.md
# Nibble Accumulator ALU

This block keeps the 4-bit accumulator and the single carry flag of a small nibble-wide processor and carries out its arithmetic and flag operations. The surrounding sequencer presents an operation code and a 4-bit operand, taken from a register or a RAM nibble, and raises a strobe. The accumulator and carry then update at the next rising clock edge.

Subtraction uses carry as an active-high "no borrow" flag. Increment, decrement and the carry-transfer operations also follow fixed carry rules of their own. A combinational flag reports when the accumulator holds zero, so the sequencer can take a branch on it in the same cycle.

Top module: `nib_accum_alu`

## Requirements
- R1: While `rst_n` is low, and after it is released, the accumulator and carry read 0 and `acc_zero_o` reads 1.
- R2: The accumulator and carry hold their values in any cycle where `op_valid` is low, whatever the code. They also hold for any code from 0x11 to 0x1F and for code 0x00.
- R3: LOAD (code 0x01) copies the operand into the accumulator and leaves carry unchanged.
- R4: ADD (code 0x02) forms accumulator + operand + carry. The accumulator takes bits 3:0 of the sum and carry takes bit 4.
- R5: SUBR (code 0x03) forms accumulator + carry + (operand XOR 0xF). The accumulator takes bits 3:0 and carry takes bit 4, so carry 1 means no borrow.
- R6: SUBM (code 0x04) forms accumulator + 16 − operand − carry. The accumulator takes bits 3:0 and carry takes bit 4.
- R7: INC (code 0x05) adds 1 modulo 16 and sets carry only when the result is 0. DEC (code 0x06) subtracts 1 modulo 16 and sets carry except when the result is 15.
- R8: DADJ (code 0x07) acts only when the accumulator is at least 10 or carry is 1. It then adds 6. If the sum reaches 16, 16 is removed and carry is set; otherwise carry is kept.
- R9: ROTL (code 0x08) moves carry into bit 0 and the old bit 3 into carry. ROTR (code 0x09) moves carry into bit 3 and the old bit 0 into carry.
- R10: INVA (code 0x0A) inverts all four accumulator bits and keeps carry. INVC (code 0x0B) toggles carry and keeps the accumulator.
- R11: ZERO (code 0x0C) clears both the accumulator and carry. CLRC (code 0x0D) clears carry only. SETC (code 0x0E) sets carry only.
- R12: MOVC (code 0x0F) loads the accumulator with the carry value and then clears carry. MOVD (code 0x10) loads the accumulator with 9 + carry and then clears carry.
- R13: `acc_zero_o` is 1 exactly when the accumulator is 0, in the same cycle the accumulator takes that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 5 | Operation select |
| operand | input | 4 | Register or RAM nibble |
| acc_o | output | 4 | Accumulator |
| carry_o | output | 1 | Carry flag |
| acc_zero_o | output | 1 | Accumulator equals zero |

## Verification
In a single cycle the block both consumes the carry as an input term and writes a new carry out. This matters most when ADD, SUBR or SUBM run with carry already set and the sum crosses 16, and when DADJ runs with carry set but the accumulator below 10. The bench sets carry up on purpose with SETC, CLRC or an earlier overflow before each of these operations. The scoreboard then compares the new accumulator and carry against a nibble model that has already taken the old carry into account. The zero flag is compared in the same sample, so an overflow that wraps to 0 also tests R13.

// File: rtl/nib_accum_alu.sv
module nib_accum_alu #(
  parameter int W = 4,
  parameter int OPW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [W-1:0]   operand,
  output logic [W-1:0]   acc_o,
  output logic           carry_o,
  output logic           acc_zero_o
);

  localparam logic [OPW-1:0] OP_LOAD = 5'h01;
  localparam logic [OPW-1:0] OP_ADD  = 5'h02;
  localparam logic [OPW-1:0] OP_SUBR = 5'h03;
  localparam logic [OPW-1:0] OP_SUBM = 5'h04;
  localparam logic [OPW-1:0] OP_INC  = 5'h05;
  localparam logic [OPW-1:0] OP_DEC  = 5'h06;
  localparam logic [OPW-1:0] OP_DADJ = 5'h07;
  localparam logic [OPW-1:0] OP_ROTL = 5'h08;
  localparam logic [OPW-1:0] OP_ROTR = 5'h09;
  localparam logic [OPW-1:0] OP_INVA = 5'h0A;
  localparam logic [OPW-1:0] OP_INVC = 5'h0B;
  localparam logic [OPW-1:0] OP_ZERO = 5'h0C;
  localparam logic [OPW-1:0] OP_CLRC = 5'h0D;
  localparam logic [OPW-1:0] OP_SETC = 5'h0E;
  localparam logic [OPW-1:0] OP_MOVC = 5'h0F;
  localparam logic [OPW-1:0] OP_MOVD = 5'h10;

  localparam logic [W:0] MODV  = W'(0) + (1 << W);
  localparam logic [W-1:0] ALL1 = '1;
  localparam logic [W-1:0] DEC_LIM = 4'd10;
  localparam logic [W-1:0] DEC_ADJ = 4'd6;
  localparam logic [W-1:0] DEC_BASE = 4'd9;

  logic [W-1:0] acc_q, acc_d;
  logic         cy_q, cy_d;

  logic [W:0] cy_ext;
  assign cy_ext = {{W{1'b0}}, cy_q};

  logic [W:0] sum_add, sum_subr, sum_subm, sum_adj;
  assign sum_add  = {1'b0, acc_q} + {1'b0, operand} + cy_ext;
  assign sum_subr = {1'b0, acc_q} + {1'b0, ~operand} + cy_ext;
  assign sum_subm = {1'b0, acc_q} + MODV - {1'b0, operand} - cy_ext;
  assign sum_adj  = {1'b0, acc_q} + {1'b0, DEC_ADJ};

  logic [W-1:0] inc_v, dec_v;
  assign inc_v = acc_q + 1'b1;
  assign dec_v = acc_q - 1'b1;

  logic adj_go;
  assign adj_go = (acc_q >= DEC_LIM) || cy_q;

  always_comb begin
    acc_d = acc_q;
    cy_d  = cy_q;
    unique case (op_code)
      OP_LOAD: acc_d = operand;
      OP_ADD:  {cy_d, acc_d} = sum_add;
      OP_SUBR: {cy_d, acc_d} = sum_subr;
      OP_SUBM: {cy_d, acc_d} = sum_subm;
      OP_INC: begin
        acc_d = inc_v;
        cy_d  = (inc_v == '0);
      end
      OP_DEC: begin
        acc_d = dec_v;
        cy_d  = (dec_v != ALL1);
      end
      OP_DADJ: begin
        if (adj_go) begin
          acc_d = sum_adj[W-1:0];
          if (sum_adj[W]) cy_d = 1'b1;
        end
      end
      OP_ROTL: begin
        acc_d = {acc_q[W-2:0], cy_q};
        cy_d  = acc_q[W-1];
      end
      OP_ROTR: begin
        acc_d = {cy_q, acc_q[W-1:1]};
        cy_d  = acc_q[0];
      end
      OP_INVA: acc_d = acc_q ^ ALL1;
      OP_INVC: cy_d = ~cy_q;
      OP_ZERO: begin
        acc_d = '0;
        cy_d  = 1'b0;
      end
      OP_CLRC: cy_d = 1'b0;
      OP_SETC: cy_d = 1'b1;
      OP_MOVC: begin
        acc_d = {{(W-1){1'b0}}, cy_q};
        cy_d  = 1'b0;
      end
      OP_MOVD: begin
        acc_d = DEC_BASE + {{(W-1){1'b0}}, cy_q};
        cy_d  = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
    end else if (op_valid) begin
      acc_q <= acc_d;
      cy_q  <= cy_d;
    end
  end

  assign acc_o      = acc_q;
  assign carry_o    = cy_q;
  assign acc_zero_o = ~|acc_q;

endmodule

// File: rtl/nib_accum_alu_chk.sv
module nib_accum_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [4:0] op_code,
  input logic [3:0] operand,
  input logic [3:0] acc_o,
  input logic       carry_o,
  input logic       acc_zero_o
);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc_o) && $stable(carry_o)));

  // R3
  load_keep_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 5'h01) |=> (acc_o == $past(operand) && carry_o == $past(carry_o)));

  // R7
  inc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 5'h05) |=> (carry_o == (acc_o == 4'd0)));

  // R10
  inv_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 5'h0B) |=> (carry_o != $past(carry_o) && $stable(acc_o)));

  // R11
  zero_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 5'h0C) |=> (acc_o == 4'd0 && !carry_o));

  // R12
  move_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 5'h0F) |=> (acc_o == {3'b000, $past(carry_o)} && !carry_o));

  // R13
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 5'h0C) |=> acc_zero_o);

endmodule

bind nib_accum_alu nib_accum_alu_chk chk_i (.*);

// File: tb/nib_accum_alu_tb_top.sv
module nib_accum_alu_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [3:0] operand = '0;
  logic [3:0] acc_o;
  logic       carry_o;
  logic       acc_zero_o;

  always #2 clk = ~clk;

  nib_accum_alu dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .acc_o(acc_o), .carry_o(carry_o), .acc_zero_o(acc_zero_o)
  );

  int checks = 0;
  int errors = 0;
  logic [3:0] m_acc = '0;
  logic       m_cy = 1'b0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  task automatic model(input logic v, input logic [4:0] op, input logic [3:0] d);
    int s;
    logic c0;
    if (!v) return;
    c0 = m_cy;
    case (op)
      5'h01: m_acc = d;
      5'h02: begin s = m_acc + d + c0; m_acc = s[3:0]; m_cy = s[4]; end
      5'h03: begin s = m_acc + c0 + (15 - d); m_acc = s[3:0]; m_cy = s[4]; end
      5'h04: begin s = m_acc + 16 - d - c0; m_acc = s[3:0]; m_cy = s[4]; end
      5'h05: begin m_acc = m_acc + 4'd1; m_cy = (m_acc == 0); end
      5'h06: begin m_acc = m_acc - 4'd1; m_cy = (m_acc != 15); end
      5'h07: if (m_acc >= 10 || c0) begin
               s = m_acc + 6;
               if (s >= 16) begin m_acc = 4'(s - 16); m_cy = 1'b1; end
               else m_acc = 4'(s);
             end
      5'h08: begin m_cy = m_acc[3]; m_acc = {m_acc[2:0], c0}; end
      5'h09: begin m_cy = m_acc[0]; m_acc = {c0, m_acc[3:1]}; end
      5'h0A: m_acc = ~m_acc;
      5'h0B: m_cy = ~c0;
      5'h0C: begin m_acc = 0; m_cy = 0; end
      5'h0D: m_cy = 0;
      5'h0E: m_cy = 1;
      5'h0F: begin m_acc = {3'b000, c0}; m_cy = 0; end
      5'h10: begin m_acc = 4'd9 + {3'b000, c0}; m_cy = 0; end
      default: ;
    endcase
  endtask

  task automatic drive(input logic v, input logic [4:0] op, input logic [3:0] d, input string tag);
    @(negedge clk);
    op_valid = v;
    op_code  = op;
    operand  = d;
    model(v, op, d);
    exp_q.push_back({m_cy, m_acc});
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      int n;
      @(posedge clk);
      n = exp_q.size();
      @(negedge clk);
      repeat (n) begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({carry_o, acc_o} !== e) begin
          errors++;
          $display("FAIL %s acc/cy actual %h/%b expected %h/%b", t, acc_o, carry_o, e[3:0], e[4]);
        end
        checks++;
        if (acc_zero_o !== (e[3:0] == 4'd0)) begin
          errors++;
          $display("FAIL R13 zero flag actual %b expected %b", acc_zero_o, e[3:0] == 4'd0);
        end
      end
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    checks++;
    if (acc_o !== 4'd0 || carry_o !== 1'b0 || acc_zero_o !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset actual %h/%b/%b expected 0/0/1", acc_o, carry_o, acc_zero_o);
    end
    rst_n = 1'b1;
    drive(1, 5'h01, 4'd7, "R3");
    drive(1, 5'h02, 4'd9, "R4");
    drive(1, 5'h02, 4'd5, "R4");
    drive(1, 5'h01, 4'd3, "R3");
    drive(1, 5'h0E, 4'd0, "R11");
    drive(1, 5'h03, 4'd5, "R5");
    drive(1, 5'h03, 4'd1, "R5");
    drive(1, 5'h04, 4'd4, "R6");
    drive(1, 5'h0D, 4'd0, "R11");
    drive(1, 5'h04, 4'd9, "R6");
    drive(1, 5'h01, 4'd15, "R3");
    drive(1, 5'h05, 4'd0, "R7");
    drive(1, 5'h05, 4'd0, "R7");
    drive(1, 5'h01, 4'd0, "R3");
    drive(1, 5'h06, 4'd0, "R7");
    drive(1, 5'h06, 4'd0, "R7");
    drive(1, 5'h01, 4'd11, "R3");
    drive(1, 5'h0D, 4'd0, "R11");
    drive(1, 5'h07, 4'd0, "R8");
    drive(1, 5'h01, 4'd4, "R3");
    drive(1, 5'h07, 4'd0, "R8");
    drive(1, 5'h0D, 4'd0, "R11");
    drive(1, 5'h01, 4'd5, "R3");
    drive(1, 5'h07, 4'd0, "R8");
    drive(1, 5'h01, 4'd9, "R3");
    drive(1, 5'h08, 4'd0, "R9");
    drive(1, 5'h08, 4'd0, "R9");
    drive(1, 5'h09, 4'd0, "R9");
    drive(1, 5'h09, 4'd0, "R9");
    drive(1, 5'h0A, 4'd0, "R10");
    drive(1, 5'h0B, 4'd0, "R10");
    drive(1, 5'h0B, 4'd0, "R10");
    drive(0, 5'h0C, 4'd0, "R2");
    drive(1, 5'h1F, 4'd0, "R2");
    drive(1, 5'h00, 4'd3, "R2");
    drive(1, 5'h0E, 4'd0, "R11");
    drive(1, 5'h0F, 4'd0, "R12");
    drive(1, 5'h0F, 4'd0, "R12");
    drive(1, 5'h0E, 4'd0, "R11");
    drive(1, 5'h10, 4'd0, "R12");
    drive(1, 5'h10, 4'd0, "R12");
    drive(1, 5'h0C, 4'd0, "R11");
    drive(0, 5'h0E, 4'd0, "R2");
    @(negedge clk);
    op_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule